// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits between the two programmable dividers of a frequency synthesizer and the charge pump. It watches the divided reference and the divided oscillator pulse trains, which are sampled on a fast system clock. Each rising edge of either train sets a latch. The reference latch asks for more current from the source side, and the oscillator latch asks for the sink side. When both latches are set, they stay set together for a programmable number of fast cycles. This overlap is an anti-backlash pulse that keeps the pump out of its dead zone. After the overlap both latches clear.

A polarity input decides which latch drives the source switch and which drives the sink switch, so the block can serve loops whose oscillator tunes either way. A 3-bit current step code is passed straight through to the analog pump. A lock indicator is low only while exactly one latch is set, so its low time equals the phase error. It is high when the edges coincide. In standby the latches are held clear, both pump switches are off, and the lock pin is released to high impedance.

Two auxiliary outputs make the internal signals observable. A 2-bit mode selects what they carry: the inverted divided trains, the raw latch states in two forms, or a user bit.

Top module: `pfd_lockdet`

## Requirements
- R1: During and after reset, with standby low and both inputs low, pump_src and pump_snk are 0, lock_out is 1 and lock_hiz is 0.
- R2: A rising edge of ref_div, meaning a cycle with a 1 that follows a 0, sets the UP latch at the next clock edge. A rising edge of vco_div sets the DOWN latch the same way. Nothing else sets a latch.
- R3: With polarity = 1, pump_src follows UP and pump_snk follows DOWN. With polarity = 0 the two roles are swapped.
- R4: Once both latches are set they stay set together for W clock cycles and then both clear. W is 5, 3, 2 or 1 for abl_code 00, 01, 10 or 11.
- R5: A rising edge arriving in the cycle in which the latches clear still sets its own latch.
- R6: Outside standby, lock_out is 0 exactly while one latch is set and the other is clear, and 1 otherwise.
- R7: While standby = 1, pump_src and pump_snk are 0, lock_out is 0, lock_hiz is 1, and the latches are cleared. Input edges seen during standby have no effect afterwards.
- R8: The aux_mode field selects the auxiliary outputs as follows. Mode 00 gives aux_a = ~ref_div and aux_b = ~vco_div. Mode 01 gives aux_a = DOWN and aux_b = ~UP. Mode 10 gives aux_a = ~DOWN and aux_b = ~UP. Mode 11 gives aux_a = aux_bit and aux_b = 0. UP and DOWN here are the latch states before the polarity swap.
- R9: pump_icp always equals icp_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference pulse train |
| vco_div | input | 1 | Divided oscillator pulse train |
| polarity | input | 1 | 1: UP drives the source side, 0: swapped |
| abl_code | input | 2 | Anti-backlash overlap width code |
| icp_code | input | 3 | Pump current step code |
| standby | input | 1 | Disables the detector and releases the lock pin |
| aux_mode | input | 2 | Auxiliary output routing mode |
| aux_bit | input | 1 | User bit for routing mode 11 |
| pump_src | output | 1 | Source switch control |
| pump_snk | output | 1 | Sink switch control |
| pump_icp | output | 3 | Current step code to the pump |
| lock_out | output | 1 | Lock indicator, low during phase error |
| lock_hiz | output | 1 | Lock pin drive release (standby) |
| aux_a | output | 1 | Auxiliary output A |
| aux_b | output | 1 | Auxiliary output B |

## Verification
The hardest case to reach from the ports is a fresh edge that lands in the exact cycle in which the overlap ends. Coinciding edges clear so quickly that free-running trains seldom line this up. A directed sequence with the shortest overlap code places a reference edge two cycles after an oscillator-trailing pair to force it. Random trains with nearly equal periods and changing codes then sweep leading and lagging phase, polarity, routing and standby entry in the middle of a pulse. Every cycle is compared against a bench model that is built from the requirements.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    RT_DIV_INV   = 2'b00,
    RT_PHASE     = 2'b01,
    RT_PHASE_INV = 2'b10,
    RT_USER      = 2'b11
  } route_mode_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int ABL_C0 = 5,
  parameter int ABL_C1 = 3,
  parameter int ABL_C2 = 2,
  parameter int ABL_C3 = 1
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] rise_i,
  input  logic [1:0] abl_code,
  input  logic       sby_i,
  output logic       up_o,
  output logic       dn_o
);
  localparam int WMAX  = pfd_pkg::max4(ABL_C0, ABL_C1, ABL_C2, ABL_C3);
  localparam int CNT_W = $clog2(WMAX + 1);

  logic             up_q, dn_q, up_d, dn_d;
  logic [CNT_W-1:0] ovl_q, ovl_d, lim_m1;
  logic             both, clr;

  always_comb begin
    case (abl_code)
      2'b00:   lim_m1 = CNT_W'(ABL_C0 - 1);
      2'b01:   lim_m1 = CNT_W'(ABL_C1 - 1);
      2'b10:   lim_m1 = CNT_W'(ABL_C2 - 1);
      default: lim_m1 = CNT_W'(ABL_C3 - 1);
    endcase
  end

  assign both = up_q & dn_q;
  assign clr  = both & (ovl_q >= lim_m1);

  always_comb begin
    if (sby_i) begin
      up_d  = 1'b0;
      dn_d  = 1'b0;
      ovl_d = '0;
    end else begin
      up_d  = rise_i[0] | (up_q & ~clr);
      dn_d  = rise_i[1] | (dn_q & ~clr);
      ovl_d = (both & ~clr) ? ovl_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else begin
      up_q  <= up_d;
      dn_q  <= dn_d;
      ovl_q <= ovl_d;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  // R2: a reference edge outside standby sets UP
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rise_i[0] && !sby_i) |=> up_q);

  // R2: without an edge, a clear UP latch stays clear
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rise_i[0] && !up_q) |=> !up_q);

  // R4: the overlap count never reaches the largest width
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    both |-> (ovl_q < CNT_W'(WMAX)));

  // R7: standby clears both latches
  p_sby_clear_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    sby_i |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_route.sv
module pfd_route (
  input  logic       ref_i,
  input  logic       vco_i,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic [1:0] mode_i,
  input  logic       user_i,
  output logic       aux_a,
  output logic       aux_b
);
  import pfd_pkg::*;

  always_comb begin
    case (route_mode_e'(mode_i))
      RT_DIV_INV:   begin aux_a = ~ref_i; aux_b = ~vco_i; end
      RT_PHASE:     begin aux_a = dn_i;   aux_b = ~up_i;  end
      RT_PHASE_INV: begin aux_a = ~dn_i;  aux_b = ~up_i;  end
      default:      begin aux_a = user_i; aux_b = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int ABL_C0 = 5,
  parameter int ABL_C1 = 3,
  parameter int ABL_C2 = 2,
  parameter int ABL_C3 = 1,
  parameter int ICP_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_div,
  input  logic             vco_div,
  input  logic             polarity,
  input  logic [1:0]       abl_code,
  input  logic [ICP_W-1:0] icp_code,
  input  logic             standby,
  input  logic [1:0]       aux_mode,
  input  logic             aux_bit,
  output logic             pump_src,
  output logic             pump_snk,
  output logic [ICP_W-1:0] pump_icp,
  output logic             lock_out,
  output logic             lock_hiz,
  output logic             aux_a,
  output logic             aux_b
);
  logic [1:0] rst_sync;
  logic       rst_i;
  logic [1:0] ins, rise;
  logic       up, dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign ins = {vco_div, ref_div};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    pfd_edge u_edge (
      .clk    (clk),
      .rst_ni (rst_i),
      .sig_i  (ins[g]),
      .rise_o (rise[g])
    );
  end

  pfd_core #(
    .ABL_C0 (ABL_C0),
    .ABL_C1 (ABL_C1),
    .ABL_C2 (ABL_C2),
    .ABL_C3 (ABL_C3)
  ) u_core (
    .clk      (clk),
    .rst_ni   (rst_i),
    .rise_i   (rise),
    .abl_code (abl_code),
    .sby_i    (standby),
    .up_o     (up),
    .dn_o     (dn)
  );

  pfd_route u_route (
    .ref_i  (ref_div),
    .vco_i  (vco_div),
    .up_i   (up),
    .dn_i   (dn),
    .mode_i (aux_mode),
    .user_i (aux_bit),
    .aux_a  (aux_a),
    .aux_b  (aux_b)
  );

  assign pump_src = ~standby & (polarity ? up : dn);
  assign pump_snk = ~standby & (polarity ? dn : up);
  assign pump_icp = icp_code;
  assign lock_out = ~standby & ~(up ^ dn);
  assign lock_hiz = standby;

  // R6: the lock indicator is high only when the pump switches agree
  p_lock_match_r6: assert property (@(posedge clk) disable iff (!rst_i)
    !standby |-> (lock_out == (pump_src == pump_snk)));

  // R3: the two pump switches are both on only during an overlap, which the lock flag marks high
  p_both_on_locked_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (pump_src && pump_snk) |-> lock_out);
endmodule

// File: tb/tb_pfd_lockdet.sv
module tb_pfd_lockdet;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_div, vco_div, polarity, standby, aux_bit;
  logic [1:0] abl_code, aux_mode;
  logic [2:0] icp_code;
  logic       pump_src, pump_snk, lock_out, lock_hiz, aux_a, aux_b;
  logic [2:0] pump_icp;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic m_rq, m_vq, m_up, m_dn;
  int   m_cnt;

  always #4 clk = ~clk;

  pfd_lockdet dut (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
    .polarity(polarity), .abl_code(abl_code), .icp_code(icp_code),
    .standby(standby), .aux_mode(aux_mode), .aux_bit(aux_bit),
    .pump_src(pump_src), .pump_snk(pump_snk), .pump_icp(pump_icp),
    .lock_out(lock_out), .lock_hiz(lock_hiz), .aux_a(aux_a), .aux_b(aux_b)
  );

  function automatic int abl_w(input logic [1:0] c);
    case (c)
      2'b00:   return 5;
      2'b01:   return 3;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq = 0; m_vq = 0; m_up = 0; m_dn = 0; m_cnt = 0;
    end else begin
      logic rr, vr, both, clr;
      rr   = ref_div & ~m_rq;
      vr   = vco_div & ~m_vq;
      both = m_up & m_dn;
      clr  = both && (m_cnt >= abl_w(abl_code) - 1);
      if (standby) begin
        m_up = 0; m_dn = 0; m_cnt = 0;
      end else begin
        m_cnt = (both && !clr) ? m_cnt + 1 : 0;
        m_up  = rr | (m_up & ~clr);
        m_dn  = vr | (m_dn & ~clr);
      end
      m_rq = ref_div;
      m_vq = vco_div;
    end
  end

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    logic es, ek, el, ea, eb;
    es = !standby && (polarity ? m_up : m_dn);
    ek = !standby && (polarity ? m_dn : m_up);
    el = !standby && !(m_up ^ m_dn);
    case (aux_mode)
      2'b00:   begin ea = ~ref_div; eb = ~vco_div; end
      2'b01:   begin ea = m_dn;     eb = ~m_up;    end
      2'b10:   begin ea = ~m_dn;    eb = ~m_up;    end
      default: begin ea = aux_bit;  eb = 1'b0;     end
    endcase
    chk({2'b0, pump_src}, {2'b0, es}, "R3/R4/R5 pump_src");
    chk({2'b0, pump_snk}, {2'b0, ek}, "R3/R4/R5 pump_snk");
    chk({2'b0, lock_out}, {2'b0, el}, "R6 lock_out");
    chk({2'b0, lock_hiz}, {2'b0, standby}, "R7 lock_hiz");
    chk({1'b0, aux_a, aux_b}, {1'b0, ea, eb}, "R8 aux");
    chk(pump_icp, icp_code, "R9 pump_icp");
  endtask

  task automatic tick(input logic r, input logic v);
    @(negedge clk);
    compare_model();
    ref_div = r;
    vco_div = v;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed, tr, tv, cr, cv, ov;
    seed = $urandom(20240611);
    rst_n = 0; ref_div = 0; vco_div = 0; polarity = 1; standby = 0;
    aux_bit = 0; abl_code = 2'b00; aux_mode = 2'b01; icp_code = 3'd5;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({pump_src, pump_snk, lock_out}, 3'b001, "R1 reset outputs");
    chk({2'b0, lock_hiz}, 3'b0, "R1 lock_hiz");
    rst_n = 1;
    repeat (4) tick(0, 0);
    chk({pump_src, pump_snk, lock_out}, 3'b001, "R1 after release");

    // R2: ref edge sets UP one clock later
    tick(1, 0);
    tick(0, 0);
    chk({2'b0, pump_src}, 3'b001, "R2 UP set by ref edge");
    chk({2'b0, lock_out}, 3'b000, "R6 lock low during error");
    tick(0, 1);
    repeat (8) tick(0, 0);

    // R4: overlap width for each code with coincident edges
    for (int c = 0; c < 4; c++) begin
      abl_code = 2'(c);
      tick(1, 1);
      ov = 0;
      for (int k = 0; k < 8; k++) begin
        tick(0, 0);
        if (pump_src && pump_snk) ov++;
      end
      chk(3'(ov), 3'(abl_w(2'(c))), "R4 overlap width");
    end

    // R3: polarity swap, DOWN only -> source side
    polarity = 0;
    tick(0, 1);
    tick(0, 0);
    chk({1'b0, pump_src, pump_snk}, 3'b010, "R3 swapped polarity");
    tick(1, 0);
    repeat (6) tick(0, 0);
    polarity = 1;

    // R5: edge in the clearing cycle
    abl_code = 2'b11;
    tick(1, 0);
    tick(0, 1);
    tick(1, 0);
    tick(0, 0);
    chk({1'b0, pump_src, pump_snk}, 3'b010, "R5 edge in clear cycle");
    tick(0, 1);
    repeat (6) tick(0, 0);

    // R7: standby ignores edges
    standby = 1;
    tick(1, 0);
    tick(1, 0);
    chk({pump_src, pump_snk, lock_out}, 3'b000, "R7 standby outputs");
    chk({2'b0, lock_hiz}, 3'b001, "R7 standby hiz");
    standby = 0;
    tick(1, 0);
    tick(0, 0);
    chk({pump_src, pump_snk, lock_out}, 3'b001, "R7 edge in standby ignored");

    // random trains
    tr = 10; tv = 10; cr = 0; cv = 3;
    for (int i = 0; i < 12000; i++) begin
      if (i % 400 == 0) begin
        tr = 6 + int'($urandom % 15);
        tv = tr + int'($urandom % 5) - 2;
        polarity = 1'($urandom);
        abl_code = 2'($urandom);
        aux_mode = 2'($urandom);
        aux_bit  = 1'($urandom);
        icp_code = 3'($urandom);
        standby  = ($urandom % 8) == 0;
      end
      tick(cr < 2, cv < 2);
      cr = (cr + 1) % tr;
      cv = (cv + 1) % tv;
    end
    standby = 0;
    repeat (10) tick(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule